// File: doc/BRIEF.md
# Privileged System Control Register Bank

This unit answers register-transfer requests that a processor core forwards to its system-control coprocessor. Each request names a primary register (4 bits), a secondary selector (4 bits), a first and a second opcode field (3 bits each), and says whether it is a read or a write. It also says whether the core is running in an unprivileged mode. The unit checks every request against a fixed legality table. It then answers with either an accept ("done") or a refusal ("reject").

Accepted writes are stored after a per-register mask is applied. Each register has its own keep mask and forced-one mask. A zero second opcode selects the main bank, and a non-zero one selects a small alternate bank. Four debug words sit behind primary register 14 and are picked by the secondary selector. Accepted reads return the addressed word. The endianness bit lives in main register 1, and when a write changes it the unit raises a one-cycle pulse so the core can switch byte order.

A request is held on the request pins for one clock edge. The response appears in the following cycle and lasts for exactly one cycle.

Top module: `sysctl_bank`

## Requirements
- R1: A request made with `req_user`=1, or with a non-zero `req_op1`, is rejected. Such a request changes no stored state.
- R2: Legality of registers other than 7, 8 and 14, when privileged with `req_op1`=0:
  - Registers 4, 11 and 12 always reject.
  - Registers 0 and 1 accept selector 0 with any second opcode.
  - Registers 2, 3, 5, 6 and 13 need selector 0 and second opcode 0.
  - Register 9 needs selector 0 or 1 and second opcode 0, 1 or 2.
  - Register 10 needs selector 0 or 1 and second opcode 0 or 4.
  - Register 15 needs selector 1 and second opcode 0.
- R3: Register 7 accepts only these (second opcode, selector) pairs: (0,5), (0,6), (0,7), (1,5), (1,6), (1,10), (4,10), (5,2) and (6,5). Register 8 accepts second opcode 0 with selector 5 to 7, and second opcode 1 with selector 5 or 6.
- R4: Register 14 accepts only second opcode 0 together with selector 0, 3, 4, 8 or 9.
- R5: After reset, every stored word reads zero, except three:
  - Main register 0 reads the parameter `ID_WORD`.
  - Alternate register 0 reads the parameter `CTYPE_WORD`.
  - Main register 1 reads 0x78.
- R6: Main-bank writes (second opcode 0) store the value `(wdata & keep) | force`. `force` is 0x78 for register 1 and zero elsewhere. The keep masks are:

  | Register | keep mask |
  |---|---|
  | 1 | 0x00003B87 |
  | 2 | 0xFFFFC000 |
  | 3 | all ones |
  | 5 | 0x000006FF |
  | 6 | all ones |
  | 9 | 0x00000001 |
  | 13 | 0xFE000000 |
  | 14, selector 0 | all ones |
  | 15 | 0x00003FFF |

- R7: Accepted writes to main registers 0, 7, 8 and 10 are ignored. Reads of main registers 7, 8 and 10 return zero.
- R8: A non-zero second opcode addresses the alternate bank:
  - Register 0 is read-only.
  - Register 1 keeps bits 5:4 and 1:0 (mask 0x33).
  - Every other alternate register drops writes and reads zero.
- R9: Under register 14, selectors 3, 4, 8 and 9 address four separate debug words. These are distinct from the word at selector 0, for both read and write.
- R10: A request sampled at a clock edge produces, in the next cycle only, exactly one of `rsp_done` or `rsp_reject`. `rsp_rdata` carries the read value together with `rsp_done` on an accepted read, and is zero otherwise.
- R11: An accepted write that changes bit 7 of main register 1 pulses `endian_flip` for one cycle, aligned with its `rsp_done`. Any other write leaves it low.
- R12: While `req_valid` is low, no response is given and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Core is in an unprivileged mode |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary selector |
| req_op1 | input | 3 | First opcode field |
| req_op2 | input | 3 | Second opcode field (bank select) |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | Request accepted |
| rsp_reject | output | 1 | Request refused |
| rsp_rdata | output | 32 | Read data, zero unless an accepted read |
| endian_flip | output | 1 | One-cycle pulse on endianness bit change |

## Verification
The endianness pulse is the hardest case to reach. It needs a privileged write to main register 1 with both opcodes and the selector at zero, and the written bit 7 must differ from the stored one. Uniform random fields almost never line up this way. The stimulus therefore biases the second opcode, the first opcode and the selector toward zero, adds directed toggles of bit 7, and adds rewrites of the same value that must not pulse. The alternate bank and the four debug words behind register 14 are reached in the same way. Read-backs follow the writes so that every stored word is observed through the read port.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int XLEN    = 32;
    localparam int NREG    = 16;
    localparam int NDBG    = 4;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int DIDX_W  = $clog2(NDBG);

    typedef logic [XLEN-1:0]            word_t;
    typedef logic [NREG-1:0][XLEN-1:0]  bank_t;
    typedef logic [NDBG-1:0][XLEN-1:0]  dbg_t;

    localparam word_t CTL_FORCE = 32'h0000_0078;

    // Bits of a main-bank register that a write may change.
    function automatic word_t keep_mask(input logic [RIDX_W-1:0] crn);
        case (crn)
            4'd1:          keep_mask = 32'h0000_3B87;
            4'd2:          keep_mask = 32'hFFFF_C000;
            4'd3, 4'd6,
            4'd14:         keep_mask = 32'hFFFF_FFFF;
            4'd5:          keep_mask = 32'h0000_06FF;
            4'd9:          keep_mask = 32'h0000_0001;
            4'd13:         keep_mask = 32'hFE00_0000;
            4'd15:         keep_mask = 32'h0000_3FFF;
            default:       keep_mask = '0;
        endcase
    endfunction

    // Bits forced to one on every write.
    function automatic word_t force_mask(input logic [RIDX_W-1:0] crn);
        force_mask = (crn == 4'd1) ? CTL_FORCE : '0;
    endfunction

    function automatic logic main_writable(input logic [RIDX_W-1:0] crn);
        main_writable = (keep_mask(crn) != '0);
    endfunction

    function automatic logic dbg_hit(input logic [3:0] crm);
        dbg_hit = (crm == 4'd3) || (crm == 4'd4) || (crm == 4'd8) || (crm == 4'd9);
    endfunction

    function automatic logic [DIDX_W-1:0] dbg_index(input logic [3:0] crm);
        case (crm)
            4'd3:    dbg_index = 2'd0;
            4'd4:    dbg_index = 2'd1;
            4'd8:    dbg_index = 2'd2;
            default: dbg_index = 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/sysctl_access_check.sv
module sysctl_access_check
    import sysctl_pkg::*;
(
    input  logic                user,
    input  logic [RIDX_W-1:0]   crn,
    input  logic [3:0]          crm,
    input  logic [2:0]          op1,
    input  logic [2:0]          op2,
    output logic                legal
);
    logic crm_zero, op2_zero, tbl_ok;

    assign crm_zero = (crm == 4'd0);
    assign op2_zero = (op2 == 3'd0);

    always_comb begin
        tbl_ok = 1'b0;
        case (crn)
            4'd0, 4'd1:                    tbl_ok = crm_zero;
            4'd2, 4'd3, 4'd5, 4'd6, 4'd13: tbl_ok = crm_zero && op2_zero;
            4'd7: begin
                case (op2)
                    3'd0:    tbl_ok = (crm >= 4'd5) && (crm <= 4'd7);
                    3'd1:    tbl_ok = (crm == 4'd5) || (crm == 4'd6) || (crm == 4'd10);
                    3'd4:    tbl_ok = (crm == 4'd10);
                    3'd5:    tbl_ok = (crm == 4'd2);
                    3'd6:    tbl_ok = (crm == 4'd5);
                    default: tbl_ok = 1'b0;
                endcase
            end
            4'd8:  tbl_ok = (op2_zero && (crm >= 4'd5) && (crm <= 4'd7))
                         || ((op2 == 3'd1) && ((crm == 4'd5) || (crm == 4'd6)));
            4'd9:  tbl_ok = (crm <= 4'd1) && (op2 <= 3'd2);
            4'd10: tbl_ok = (crm <= 4'd1) && (op2_zero || (op2 == 3'd4));
            4'd14: tbl_ok = op2_zero && (crm_zero || dbg_hit(crm));
            4'd15: tbl_ok = (crm == 4'd1) && op2_zero;
            default: tbl_ok = 1'b0;
        endcase
    end

    assign legal = !user && (op1 == 3'd0) && tbl_ok;
endmodule

// File: rtl/sysctl_read_mux.sv
module sysctl_read_mux
    import sysctl_pkg::*;
#(
    parameter word_t CTYPE_WORD = 32'h0C2B_B2C1
) (
    input  logic [RIDX_W-1:0]   crn,
    input  logic [3:0]          crm,
    input  logic [2:0]          op2,
    input  bank_t               main_bank,
    input  word_t               alt_ctl,
    input  dbg_t                dbg_regs,
    output word_t               rword
);
    always_comb begin
        rword = '0;
        if (op2 != 3'd0) begin
            if (crn == 4'd0)      rword = CTYPE_WORD;
            else if (crn == 4'd1) rword = alt_ctl;
        end else if (crn == 4'd14 && dbg_hit(crm)) begin
            rword = dbg_regs[dbg_index(crm)];
        end else if (crn == 4'd15 && crm != 4'd1) begin
            rword = '0;
        end else begin
            rword = main_bank[crn];
        end
    end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_WORD    = 32'h4D31_0A05,
    parameter logic [31:0] CTYPE_WORD = 32'h0C2B_B2C1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_user,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op1,
    input  logic [2:0]  req_op2,
    input  logic [31:0] req_wdata,
    output logic        rsp_done,
    output logic        rsp_reject,
    output logic [31:0] rsp_rdata,
    output logic        endian_flip
);
    localparam int ENDIAN_BIT = 7;
    localparam word_t ALT_KEEP = 32'h0000_0033;

    typedef struct packed {
        bank_t  main;
        word_t  alt_ctl;
        dbg_t   dbg;
        logic   done;
        logic   reject;
        logic   flip;
        word_t  rdata;
    } state_t;

    state_t st_d, st_q;
    logic   legal;
    word_t  rword, main_new;

    sysctl_access_check u_check (
        .user  (req_user),
        .crn   (req_crn),
        .crm   (req_crm),
        .op1   (req_op1),
        .op2   (req_op2),
        .legal (legal)
    );

    sysctl_read_mux #(.CTYPE_WORD(CTYPE_WORD)) u_rmux (
        .crn       (req_crn),
        .crm       (req_crm),
        .op2       (req_op2),
        .main_bank (st_q.main),
        .alt_ctl   (st_q.alt_ctl),
        .dbg_regs  (st_q.dbg),
        .rword     (rword)
    );

    assign main_new = (req_wdata & keep_mask(req_crn)) | force_mask(req_crn);

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.reject = 1'b0;
        st_d.flip   = 1'b0;
        st_d.rdata  = '0;
        if (req_valid) begin
            st_d.done   = legal;
            st_d.reject = !legal;
            if (legal && !req_write) begin
                st_d.rdata = rword;
            end
            if (legal && req_write) begin
                if (req_op2 != 3'd0) begin
                    if (req_crn == 4'd1)
                        st_d.alt_ctl = req_wdata & ALT_KEEP;
                end else if (req_crn == 4'd14 && dbg_hit(req_crm)) begin
                    st_d.dbg[dbg_index(req_crm)] = req_wdata;
                end else if (main_writable(req_crn)) begin
                    st_d.main[req_crn] = main_new;
                    if (req_crn == 4'd1 &&
                        main_new[ENDIAN_BIT] != st_q.main[1][ENDIAN_BIT])
                        st_d.flip = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.main[0] <= ID_WORD;
            st_q.main[1] <= CTL_FORCE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_done    = st_q.done;
    assign rsp_reject  = st_q.reject;
    assign rsp_rdata   = st_q.rdata;
    assign endian_flip = st_q.flip;

    p_resp_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done && rsp_reject));
    p_resp_given_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_done || rsp_reject));
    p_no_req_no_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_done || rsp_reject));
    p_reject_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reject |-> (rsp_rdata == '0));
    p_user_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_user || req_op1 != 3'd0)) |=> rsp_reject);
    p_flip_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        endian_flip |-> (rsp_done && $past(req_write) && $past(req_crn) == 4'd1));
endmodule

// File: tb/tb_sysctl_bank.sv
`timescale 1ns/1ps
module tb_sysctl_bank;
    localparam time CLK_PER = 20ns;
    localparam logic [31:0] ID_C    = 32'h4D31_0A05;
    localparam logic [31:0] CTYPE_C = 32'h0C2B_B2C1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [3:0]  req_crn = '0, req_crm = '0;
    logic [2:0]  req_op1 = '0, req_op2 = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done, rsp_reject, endian_flip;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_main [16];
    logic [31:0] m_alt1;
    logic [31:0] m_dbg [4];

    always #(CLK_PER/2) clk = ~clk;

    sysctl_bank dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_user(req_user), .req_crn(req_crn), .req_crm(req_crm),
        .req_op1(req_op1), .req_op2(req_op2), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_reject(rsp_reject), .rsp_rdata(rsp_rdata),
        .endian_flip(endian_flip)
    );

    initial begin
        #(CLK_PER * 200000);
        errors++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit in_list(input logic [3:0] v, input logic [3:0] a, b, c, d, e);
        return v == a || v == b || v == c || v == d || v == e;
    endfunction

    function automatic bit m_legal(input logic us, input logic [3:0] crn, crm,
                                   input logic [2:0] o1, o2);
        if (us || o1 != 0) return 0;
        case (crn)
            0, 1:             return crm == 0;
            2, 3, 5, 6, 13:   return crm == 0 && o2 == 0;
            7: return (o2 == 0 && crm >= 5 && crm <= 7) ||
                      (o2 == 1 && in_list(crm, 5, 6, 10, 10, 10)) ||
                      (o2 == 4 && crm == 10) || (o2 == 5 && crm == 2) ||
                      (o2 == 6 && crm == 5);
            8: return (o2 == 0 && crm >= 5 && crm <= 7) || (o2 == 1 && (crm == 5 || crm == 6));
            9: return crm <= 1 && o2 <= 2;
            10: return crm <= 1 && (o2 == 0 || o2 == 4);
            14: return o2 == 0 && in_list(crm, 0, 3, 4, 8, 9);
            15: return crm == 1 && o2 == 0;
            default: return 0;
        endcase
    endfunction

    function automatic int didx(input logic [3:0] crm);
        return crm == 3 ? 0 : crm == 4 ? 1 : crm == 8 ? 2 : 3;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] crn, crm, input logic [2:0] o2);
        if (o2 != 0) return crn == 0 ? CTYPE_C : crn == 1 ? m_alt1 : 32'h0;
        if (crn == 0) return ID_C;
        if (crn == 14 && in_list(crm, 3, 4, 8, 9, 9)) return m_dbg[didx(crm)];
        if (crn == 15 && crm != 1) return 0;
        return m_main[crn];
    endfunction

    function automatic logic [31:0] m_keep(input logic [3:0] crn);
        case (crn)
            1: return 32'h0000_3B87;  2: return 32'hFFFF_C000;
            3, 6, 14: return 32'hFFFF_FFFF;
            5: return 32'h0000_06FF;  9: return 32'h1;
            13: return 32'hFE00_0000; 15: return 32'h0000_3FFF;
            default: return 0;
        endcase
    endfunction

    function automatic string data_tag(input logic [3:0] crn, crm, input logic [2:0] o2);
        if (o2 != 0) return "R8";
        if (crn == 14 && crm != 0) return "R9";
        if (crn == 0 || crn == 7 || crn == 8 || crn == 10) return "R7";
        return "R6";
    endfunction

    function automatic string legal_tag(input logic us, input logic [3:0] crn,
                                        input logic [2:0] o1);
        if (us || o1 != 0) return "R1";
        if (crn == 7 || crn == 8) return "R3";
        if (crn == 14) return "R4";
        return "R2";
    endfunction

    // One request; called and returns at a falling edge.
    task automatic access(input logic wr, us, input logic [3:0] crn, crm,
                          input logic [2:0] o1, o2, input logic [31:0] wd,
                          input string dtag = "");
        bit lg;
        logic [31:0] er, nv;
        logic ef;
        lg = m_legal(us, crn, crm, o1, o2);
        er = (lg && !wr) ? m_read(crn, crm, o2) : 32'h0;
        ef = 0;
        nv = 0;
        if (lg && wr && o2 == 0 && crn == 1) begin
            nv = (wd & 32'h3B87) | 32'h78;
            ef = nv[7] != m_main[1][7];
        end
        req_valid = 1; req_write = wr; req_user = us; req_crn = crn; req_crm = crm;
        req_op1 = o1; req_op2 = o2; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        check(legal_tag(us, crn, o1), "done", {31'h0, rsp_done}, {31'h0, lg});
        check("R10", "reject", {31'h0, rsp_reject}, {31'h0, !lg});
        check(dtag != "" ? dtag : (lg ? data_tag(crn, crm, o2) : "R10"),
              "rdata", rsp_rdata, er);
        check("R11", "endian_flip", {31'h0, endian_flip}, {31'h0, ef});
        if (lg && wr) begin
            if (o2 != 0) begin
                if (crn == 1) m_alt1 = wd & 32'h33;
            end else if (crn == 14 && crm != 0) begin
                m_dbg[didx(crm)] = wd;
            end else if (m_keep(crn) != 0) begin
                m_main[crn] = (wd & m_keep(crn)) | (crn == 1 ? 32'h78 : 32'h0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) m_main[i] = 0;
        m_main[0] = ID_C;
        m_main[1] = 32'h78;
        m_alt1 = 0;
        for (int i = 0; i < 4; i++) m_dbg[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check("R12", "idle done", {31'h0, rsp_done}, 32'h0);
        check("R12", "idle reject", {31'h0, rsp_reject}, 32'h0);

        // Reset values
        access(0, 0, 0, 0, 0, 0, 0, "R5");
        access(0, 0, 1, 0, 0, 0, 0, "R5");
        access(0, 0, 0, 0, 0, 3, 0, "R5");
        access(0, 0, 3, 0, 0, 0, 0, "R5");
        access(0, 0, 14, 8, 0, 0, 0, "R5");

        // Endianness: toggle, re-write same, toggle back
        access(1, 0, 1, 0, 0, 0, 32'hFFFF_FFFF);
        access(1, 0, 1, 0, 0, 0, 32'h0000_0080);
        access(1, 0, 1, 0, 0, 0, 32'h0000_0000);
        access(1, 0, 1, 0, 0, 2, 32'hFFFF_FFFF);
        access(0, 0, 1, 0, 0, 2, 0);
        access(0, 0, 1, 0, 0, 0, 0);
        // Privilege and first-opcode rejects leave state alone
        access(1, 1, 3, 0, 0, 0, 32'hDEAD_BEEF);
        access(1, 0, 3, 0, 1, 0, 32'hDEAD_BEEF);
        access(0, 0, 3, 0, 0, 0, 0, "R1");
        // Masks, ignored writes, debug words
        access(1, 0, 15, 1, 0, 0, 32'hFFFF_FFFF);
        access(0, 0, 15, 1, 0, 0, 0);
        access(1, 0, 0, 0, 0, 0, 32'h1234_5678);
        access(0, 0, 0, 0, 0, 0, 0);
        access(1, 0, 0, 0, 0, 1, 32'h1234_5678);
        access(0, 0, 0, 0, 0, 1, 0);
        access(1, 0, 7, 5, 0, 0, 32'hFFFF_FFFF);
        access(0, 0, 7, 6, 0, 0, 0);
        for (int k = 0; k < 5; k++) begin
            logic [3:0] s;
            s = (k == 0) ? 4'd0 : (k == 1) ? 4'd3 : (k == 2) ? 4'd4 : (k == 3) ? 4'd8 : 4'd9;
            access(1, 0, 14, s, 0, 0, 32'hA500_0000 | k);
        end
        for (int k = 0; k < 5; k++) begin
            logic [3:0] s;
            s = (k == 0) ? 4'd0 : (k == 1) ? 4'd3 : (k == 2) ? 4'd4 : (k == 3) ? 4'd8 : 4'd9;
            access(0, 0, 14, s, 0, 0, 0);
        end
        access(0, 0, 14, 5, 0, 0, 0);
        access(0, 0, 4, 0, 0, 0, 0);
        access(0, 0, 8, 7, 0, 1, 0);
        access(0, 0, 7, 10, 0, 4, 0);

        // Biased random traffic
        for (int n = 0; n < 4000; n++) begin
            logic wr, us;
            logic [3:0] crn, crm;
            logic [2:0] o1, o2;
            wr  = $urandom_range(0, 1);
            us  = ($urandom_range(0, 9) == 0);
            o1  = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
            o2  = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(0, 7));
            crn = 4'($urandom_range(0, 15));
            case ($urandom_range(0, 3))
                0:       crm = 4'd0;
                1:       crm = 4'd1;
                default: crm = 4'($urandom_range(0, 15));
            endcase
            if ($urandom_range(0, 5) == 0) begin
                crn = 1; crm = 0; o1 = 0; us = 0; wr = 1;
            end
            access(wr, us, crn, crm, o1, o2, $urandom());
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                check("R12", "idle response", {30'h0, rsp_done, rsp_reject}, 32'h0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule